// File: doc/BRIEF.md
# Line-Printer Carriage Tape Controller

This block models the paper motion and print timing of a line printer. The vertical format comes from a 12-channel carriage control tape, kept as a small on-chip image with one row per form line. Each row holds one bit per channel, and a set bit is a punched hole. A host write port replaces rows of the image. A command port accepts three operations: skip to the next line that has a hole in any of a set of channels, space one line, and start a print.

Motion runs one line at a time. Each line costs a fixed number of divider ticks. The line counter wraps from the last form line back to line 1. A skip that goes once around the whole form without finding a hole stops and reports a runaway error, so it cannot loop forever. A print waits for a strobe that marks the end of the line data transfer. It raises a transfer-complete request at once and a print-complete request after a fixed delay. Each request is held, with its status code stable, until the processor acknowledges it. The block stays busy until the last request of an operation is acknowledged, and it ignores commands while busy.

Top module: `carriage_tape_ctrl`

## Requirements
- R1: After reset, `line_o` is 1, `busy_o` and `irq_o` are 0, and the tape image holds the default pattern. Channel 1 has a hole on line 1. Channels 9 and 12 have holes on the last line. Every other channel c has a hole on line 5*c. Channel n is bit n-1 of every row and mask.
- R2: A cycle with `tw_en_i` high and `tw_line_i` between 1 and LINES replaces that row with `tw_row_i`. A write to any other line number changes nothing.
- R3: A skip (`cmd_op_i` = 2'b01) moves forward one line at a time, wrapping from line LINES to line 1. It stops on the first line after the current one whose row has a hole in any channel set in `cmd_mask_i`, then raises a request with status 2'b00 (motion done).
- R4: Each line moved costs LINE_TICKS ticks of TICK_DIV clocks. The request of a motion of n lines rises n*LINE_TICKS*TICK_DIV clocks after the edge that accepted the command.
- R5: A space (`cmd_op_i` = 2'b10) moves exactly one line, ignores the mask, and raises status 2'b00 after one line time.
- R6: If a skip moves LINES lines without a match, it stops on its starting line and raises status 2'b11 (runaway).
- R7: A print start (`cmd_op_i` = 2'b11) keeps the block busy until `xfer_done_i` is seen, then raises status 2'b01 (transfer done) on that edge.
- R8: Status 2'b10 (print done) is raised PRINT_TICKS*TICK_DIV clocks after the transfer-done edge. If the transfer-done request has not been acknowledged by then, it is raised on the first clock after the acknowledge.
- R9: `irq_o` stays high, with `irq_status_o` unchanged, until `ack_i` is sampled high.
- R10: `busy_o` is high from command accept until the final request of the operation is acknowledged. The block ignores commands while busy, commands with `cmd_op_i` = 2'b00, and `xfer_done_i` outside a print wait.
- R11: `line_o` changes only during motion, and always stays within 1..LINES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tw_en_i | input | 1 | Tape row write enable |
| tw_line_i | input | LW | Line number of the row to write (1-based) |
| tw_row_i | input | CHANNELS | Row contents, bit n-1 = channel n |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 00 none, 01 skip, 10 space, 11 print start |
| cmd_mask_i | input | CHANNELS | Channels a skip stops on |
| xfer_done_i | input | 1 | Line data transfer finished |
| ack_i | input | 1 | Interrupt acknowledge |
| busy_o | output | 1 | Operation in progress |
| irq_o | output | 1 | Interrupt request |
| irq_status_o | output | 2 | 00 motion done, 01 transfer done, 10 print done, 11 runaway |
| line_o | output | LW | Current form line |

## Verification
The embedded assertions check the invariants on every cycle: a request holds its status until acknowledged, busy covers every pending request, the line stays in range and stays still when idle, a runaway is reported only after a full lap, transfer-done comes only from the print path, and tape writes land in the addressed row. Only the bench scenarios can show the end-to-end results. These are the stop line of a skip for a given tape image and mask, wrap-around, the exact cycle count of multi-line motion and of the print delay, the late print-done after a delayed acknowledge, and that commands and strobes sent at the wrong time leave the line and the request outputs untouched.

// File: rtl/ctape_pkg.sv
package ctape_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_SKIP  = 2'b01,
    OP_SPACE = 2'b10,
    OP_PRINT = 2'b11
  } ctape_op_e;

  typedef enum logic [1:0] {
    ST_MOVE    = 2'b00,
    ST_XFER    = 2'b01,
    ST_PRINT   = 2'b10,
    ST_RUNAWAY = 2'b11
  } ctape_status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_MOVE,
    S_PR_XFER,
    S_PR_WAIT
  } ctape_state_e;

endpackage

// File: rtl/ctape_mem.sv
module ctape_mem #(
  parameter int LINES    = 66,
  parameter int CHANNELS = 12,
  localparam int LW      = $clog2(LINES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [LW-1:0]       wr_line_i,
  input  logic [CHANNELS-1:0] wr_row_i,
  input  logic [LW-1:0]       rd_line_i,
  output logic [CHANNELS-1:0] rd_row_o
);

  logic [CHANNELS-1:0] rows_q [LINES];

  // power-up form: ch1 top of form, ch9/ch12 last line, others spread
  function automatic logic [CHANNELS-1:0] default_row(int ln);
    logic [CHANNELS-1:0] r;
    r = '0;
    for (int c = 1; c <= CHANNELS; c++) begin
      if (c == 1) r[c-1] = (ln == 1);
      else if (c == 9 || c == 12) r[c-1] = (ln == LINES);
      else r[c-1] = (ln == 5 * c);
    end
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) rows_q[i] <= default_row(i + 1);
    end else begin
      for (int i = 0; i < LINES; i++)
        if (we_i && wr_line_i == LW'(i + 1)) rows_q[i] <= wr_row_i;
    end
  end

  always_comb begin
    rd_row_o = '0;
    for (int i = 0; i < LINES; i++)
      if (rd_line_i == LW'(i + 1)) rd_row_o = rows_q[i];
  end

  // R2
  row_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_line_i >= LW'(1) && wr_line_i <= LW'(LINES))
      |=> rows_q[$past(wr_line_i) - LW'(1)] == $past(wr_row_i));

endmodule

// File: rtl/ctape_tick.sv
module ctape_tick #(
  parameter int DIV = 50000,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);

  generate
    if (DIV == 1) begin : g_direct
      logic unused_in;
      assign unused_in = ^{clk_i, rst_ni, clr_i};
      assign tick_o    = en_i;
    end else begin : g_div
      logic [CW-1:0] cnt_q;

      assign tick_o = en_i && (cnt_q == CW'(DIV - 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (en_i)   cnt_q <= tick_o ? '0 : cnt_q + CW'(1);
      end

      // R4
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/ctape_seq.sv
module ctape_seq
  import ctape_pkg::*;
#(
  parameter int LINES       = 66,
  parameter int CHANNELS    = 12,
  parameter int LINE_TICKS  = 16,
  parameter int PRINT_TICKS = 200,
  localparam int LW         = $clog2(LINES + 1),
  localparam int TMAX       = (LINE_TICKS > PRINT_TICKS) ? LINE_TICKS : PRINT_TICKS,
  localparam int TW         = $clog2(TMAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [CHANNELS-1:0] cmd_mask_i,
  input  logic                xfer_done_i,
  input  logic                ack_i,
  input  logic                tick_i,
  input  logic [CHANNELS-1:0] row_i,
  output logic [LW-1:0]       probe_line_o,
  output logic                tick_clr_o,
  output logic                tick_en_o,
  output logic                busy_o,
  output logic                irq_o,
  output logic [1:0]          irq_status_o,
  output logic [LW-1:0]       line_o
);

  ctape_state_e        state_q;
  ctape_status_e       status_q;
  ctape_op_e           op;
  logic [LW-1:0]       line_q, next_line;
  logic [LW-1:0]       steps_q;
  logic [TW-1:0]       tcnt_q;
  logic [CHANNELS-1:0] mask_q;
  logic                space_q, pdone_q, irq_q;
  logic                accept, hit, line_end, print_end;

  assign op        = ctape_op_e'(cmd_op_i);
  assign busy_o    = (state_q != S_IDLE) || irq_q;
  assign accept    = cmd_valid_i && !busy_o && (op != OP_NONE);
  assign next_line = (line_q == LW'(LINES)) ? LW'(1) : line_q + LW'(1);
  assign hit       = |(row_i & mask_q);
  assign line_end  = tick_i && (tcnt_q == TW'(LINE_TICKS - 1));
  assign print_end = tick_i && (tcnt_q == TW'(PRINT_TICKS - 1));

  assign probe_line_o = next_line;
  assign tick_clr_o   = accept || (state_q == S_PR_XFER && xfer_done_i);
  assign tick_en_o    = (state_q == S_MOVE) || (state_q == S_PR_WAIT && !pdone_q);

  assign irq_o        = irq_q;
  assign irq_status_o = status_q;
  assign line_o       = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      status_q <= ST_MOVE;
      line_q   <= LW'(1);
      steps_q  <= '0;
      tcnt_q   <= '0;
      mask_q   <= '0;
      space_q  <= 1'b0;
      pdone_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (ack_i) irq_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            tcnt_q  <= '0;
            steps_q <= '0;
            pdone_q <= 1'b0;
            mask_q  <= cmd_mask_i;
            space_q <= (op == OP_SPACE);
            state_q <= (op == OP_PRINT) ? S_PR_XFER : S_MOVE;
          end
        end
        S_MOVE: begin
          if (tick_i) begin
            if (line_end) begin
              tcnt_q  <= '0;
              line_q  <= next_line;
              steps_q <= steps_q + LW'(1);
              if (space_q || hit) begin
                irq_q    <= 1'b1;
                status_q <= ST_MOVE;
                state_q  <= S_IDLE;
              end else if (steps_q == LW'(LINES - 1)) begin
                irq_q    <= 1'b1;
                status_q <= ST_RUNAWAY;
                state_q  <= S_IDLE;
              end
            end else begin
              tcnt_q <= tcnt_q + TW'(1);
            end
          end
        end
        S_PR_XFER: begin
          if (xfer_done_i) begin
            irq_q    <= 1'b1;
            status_q <= ST_XFER;
            tcnt_q   <= '0;
            state_q  <= S_PR_WAIT;
          end
        end
        S_PR_WAIT: begin
          if (tick_i && !pdone_q) begin
            if (print_end) pdone_q <= 1'b1;
            else           tcnt_q  <= tcnt_q + TW'(1);
          end
          // second request waits for the first to be acknowledged
          if ((pdone_q || print_end) && !irq_q) begin
            irq_q    <= 1'b1;
            status_q <= ST_PRINT;
            state_q  <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !ack_i) |=> (irq_q && status_q == $past(status_q)));

  // R10
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> busy_o);

  // R11
  line_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q >= LW'(1)) && (line_q <= LW'(LINES)));

  // R11
  line_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |=> $stable(line_q));

  // R6
  runaway_lap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_q) && status_q == ST_RUNAWAY) |-> steps_q == LW'(LINES));

  // R7
  xfer_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_q) && status_q == ST_XFER) |-> state_q == S_PR_WAIT);

endmodule

// File: rtl/carriage_tape_ctrl.sv
module carriage_tape_ctrl #(
  parameter int LINES       = 66,
  parameter int CHANNELS    = 12,
  parameter int TICK_DIV    = 50000,
  parameter int LINE_TICKS  = 16,
  parameter int PRINT_TICKS = 200,
  localparam int LW         = $clog2(LINES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tw_en_i,
  input  logic [LW-1:0]       tw_line_i,
  input  logic [CHANNELS-1:0] tw_row_i,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [CHANNELS-1:0] cmd_mask_i,
  input  logic                xfer_done_i,
  input  logic                ack_i,
  output logic                busy_o,
  output logic                irq_o,
  output logic [1:0]          irq_status_o,
  output logic [LW-1:0]       line_o
);

  logic                tick, tick_clr, tick_en;
  logic [LW-1:0]       probe_line;
  logic [CHANNELS-1:0] probe_row;

  ctape_mem #(
    .LINES   (LINES),
    .CHANNELS(CHANNELS)
  ) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tw_en_i),
    .wr_line_i(tw_line_i),
    .wr_row_i (tw_row_i),
    .rd_line_i(probe_line),
    .rd_row_o (probe_row)
  );

  ctape_tick #(
    .DIV(TICK_DIV)
  ) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tick_clr),
    .en_i  (tick_en),
    .tick_o(tick)
  );

  ctape_seq #(
    .LINES      (LINES),
    .CHANNELS   (CHANNELS),
    .LINE_TICKS (LINE_TICKS),
    .PRINT_TICKS(PRINT_TICKS)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_mask_i  (cmd_mask_i),
    .xfer_done_i (xfer_done_i),
    .ack_i       (ack_i),
    .tick_i      (tick),
    .row_i       (probe_row),
    .probe_line_o(probe_line),
    .tick_clr_o  (tick_clr),
    .tick_en_o   (tick_en),
    .busy_o      (busy_o),
    .irq_o       (irq_o),
    .irq_status_o(irq_status_o),
    .line_o      (line_o)
  );

endmodule

// File: tb/carriage_tape_ctrl_bench.sv
module carriage_tape_ctrl_bench;

  localparam int LINES = 66;
  localparam int CH    = 12;
  localparam int DIV   = 4;
  localparam int LT    = 16;
  localparam int PT    = 200;
  localparam int LW    = $clog2(LINES + 1);

  localparam logic [1:0] ST_MOVE = 2'b00, ST_XFER = 2'b01,
                         ST_PRINT = 2'b10, ST_RUN = 2'b11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic          tw_en = 1'b0;
  logic [LW-1:0] tw_line = '0;
  logic [CH-1:0] tw_row = '0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [CH-1:0] cmd_mask = '0;
  logic          xfer_done = 1'b0;
  logic          ack = 1'b0;
  logic          busy, irq;
  logic [1:0]    irq_status;
  logic [LW-1:0] line;

  carriage_tape_ctrl #(
    .LINES(LINES), .CHANNELS(CH), .TICK_DIV(DIV),
    .LINE_TICKS(LT), .PRINT_TICKS(PT)
  ) u_carriage_tape_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .tw_en_i(tw_en), .tw_line_i(tw_line), .tw_row_i(tw_row),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_mask_i(cmd_mask),
    .xfer_done_i(xfer_done), .ack_i(ack),
    .busy_o(busy), .irq_o(irq), .irq_status_o(irq_status), .line_o(line)
  );

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [1:0] st;
    int         ln;
    longint     at;
    string      req;
  } exp_t;

  exp_t          sb[$];
  int            total = 0;
  int            bad = 0;
  int            ack_lag = 0;
  int            cur = 1;
  logic [CH-1:0] tape [1:LINES];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor: pops expected requests and acknowledges them
  initial begin
    forever begin
      @(negedge clk);
      if (irq && !ack) begin
        exp_t e;
        logic [1:0] held;
        held = irq_status;
        if (sb.size() == 0) begin
          chk(1'b0, "R10", "unexpected request status", irq_status, 0);
        end else begin
          e = sb.pop_front();
          chk(irq_status == e.st, e.req, "status", irq_status, e.st);
          if (e.ln > 0) chk(int'(line) == e.ln, e.req, "line", line, e.ln);
          if (e.at >= 0) chk(cyc == e.at, "R4", "request cycle", cyc, e.at);
        end
        if (ack_lag > 0) begin
          repeat (ack_lag) @(negedge clk);
          chk(irq && irq_status == held, "R9", "held status", irq_status, held);
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
      end
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy || irq || sb.size() != 0);
  endtask

  task automatic issue(input logic [1:0] op, input logic [CH-1:0] mask,
                       output longint acc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_mask = mask;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    acc = cyc;
  endtask

  task automatic write_row(input int ln, input logic [CH-1:0] row);
    @(negedge clk);
    tw_en = 1'b1; tw_line = LW'(ln); tw_row = row;
    @(negedge clk);
    tw_en = 1'b0;
    if (ln >= 1 && ln <= LINES) tape[ln] = row;
  endtask

  task automatic do_skip(input logic [CH-1:0] mask, input string req);
    longint acc;
    int n, l, stop;
    logic [1:0] st;
    n = LINES; stop = cur; st = ST_RUN; l = cur;
    for (int k = 1; k <= LINES; k++) begin
      l = (l == LINES) ? 1 : l + 1;
      if ((tape[l] & mask) != '0) begin n = k; stop = l; st = ST_MOVE; break; end
    end
    issue(2'b01, mask, acc);
    sb.push_back('{st, stop, acc + longint'(n) * LT * DIV, req});
    wait_idle();
    chk(int'(line) == stop, "R11", "line after skip", line, stop);
    cur = stop;
  endtask

  task automatic do_space(input bit poke_busy);
    longint acc, dummy;
    int stop;
    stop = (cur == LINES) ? 1 : cur + 1;
    issue(2'b10, '1, acc);
    sb.push_back('{ST_MOVE, stop, acc + longint'(LT) * DIV, "R5"});
    if (poke_busy) begin
      chk(busy == 1'b1, "R10", "busy during space", busy, 1);
      issue(2'b01, CH'(1) << 11, dummy);   // ignored: block is busy
      issue(2'b11, '0, dummy);             // ignored: block is busy
    end
    wait_idle();
    chk(int'(line) == stop, "R5", "one line moved", line, stop);
    cur = stop;
  endtask

  task automatic do_print(input int lag);
    longint acc, x;
    issue(2'b11, '0, acc);
    repeat (5) @(negedge clk);
    chk(busy && !irq, "R7", "busy waiting for transfer", {busy, irq}, 2'b10);
    ack_lag = lag;
    sb.push_back('{ST_XFER, cur, -1, "R7"});
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    x = cyc;
    sb.push_back('{ST_PRINT, cur, (lag == 0) ? x + longint'(PT) * DIV : -1, "R8"});
    wait_idle();
    ack_lag = 0;
    chk(int'(line) == cur, "R11", "line kept by print", line, cur);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint dummy;
    // reference tape from R1
    for (int l = 1; l <= LINES; l++) begin
      tape[l] = '0;
      for (int c = 1; c <= CH; c++) begin
        if (c == 1) tape[l][c-1] = (l == 1);
        else if (c == 9 || c == 12) tape[l][c-1] = (l == LINES);
        else tape[l][c-1] = (l == 5 * c);
      end
    end

    repeat (3) @(negedge clk);
    chk(int'(line) == 1, "R1", "reset line", line, 1);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
    chk(irq == 1'b0, "R1", "reset irq", irq, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    do_skip(CH'(1) << 11, "R3");                 // ch12: 1 -> 66
    do_skip(CH'(1) << 0, "R3");                  // ch1 wraps: 66 -> 1
    do_space(1'b0);                              // 1 -> 2
    write_row(10, CH'(1) << 2);                  // ch3 only on line 10
    do_skip(CH'(1) << 2, "R2");                  // 2 -> 10
    do_skip(CH'(1) << 1, "R6");                  // ch2 hole overwritten: runaway
    write_row(0, '1);
    write_row(LINES + 1, '1);
    do_skip(CH'(1) << 1, "R2");                  // out-of-range writes ignored
    do_skip(CH'(1) << 8, "R3");                  // ch9: 10 -> 66
    do_skip((CH'(1) << 4) | (CH'(1) << 6), "R3"); // ch5|ch7: 66 -> 25
    do_space(1'b1);                              // busy ignores commands

    issue(2'b00, '1, dummy);
    chk(busy == 1'b0, "R10", "null op ignored", busy, 0);
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    repeat (10) @(negedge clk);
    chk(!irq && !busy, "R10", "stray transfer strobe", {irq, busy}, 0);

    do_print(0);
    do_print(PT * DIV + 40);

    chk(sb.size() == 0, "R10", "pending expectations", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule